// File: doc/BRIEF.md
# Configuration Data Streaming Readout

This block delivers a stored configuration image to a programmable logic device that is being configured. The image sits in an internal word-addressed byte store. One address counter walks through it, and the image goes out in one of two forms. In bit-serial form, single bits appear on pin 0. In byte-wide form, whole bytes appear on all eight pins. Each rising edge of the configuration clock moves the stream one step forward. In byte-wide form the target can hold the stream back by raising its busy flag.

Several of these blocks can be chained to hold an image longer than one store. When a block has delivered its last word, it lowers its chain-enable output, which selects the next block, and it releases its own data pins. A programming-mode input puts the block into a safe state: the chain-enable output goes high and every data pin is released. Pin release is shown on a per-pin enable output, where 0 means high-impedance.

Top module: `cfg_rom_stream`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge), or `oe_clr_n_i` held low (an asynchronous clear), returns the stream to address 0, bit 0, with the end flag cleared, so `chain_en_n_o` is 1.
- R2: Data pins are driven only while all of these hold: `sel_n_i`=0, `oe_clr_n_i`=1, `cfg_go_i`=1, `prog_i`=0, and the end of the store has not been reached. Otherwise `data_en_o`=8'h00 and `data_o`=8'h00.
- R3: In bit-serial form (`byte_mode_i`=0), only pin 0 is driven (`data_en_o`=8'h01, `data_o[7:1]`=0). The bits of each word are sent from bit 7 down to bit 0.
- R4: In bit-serial form, each enabled clock edge moves to the next bit. The address increments only on the edge that follows bit 0 of a word.
- R5: In byte-wide form (`byte_mode_i`=1), `data_en_o`=8'hFF and `data_o` carries the whole word. Each enabled edge with `busy_i`=0 advances the address by one.
- R6: In byte-wide form, an edge with `busy_i`=1 leaves the address unchanged, and the same byte stays on the pins.
- R7: While `sel_n_i`=1 or `cfg_go_i`=0, the pins are released and the position is held. On re-enable, the same bit or byte is presented again.
- R8: After the last word (address DEPTH-1) has been delivered, `chain_en_n_o` goes to 0 and the pins stay released until R1 clears the stream.
- R9: While `prog_i`=1, `chain_en_n_o`=1, `data_en_o`=8'h00, and the position is held.
- R10: The word at address a is (29*a + 71) mod 256. The default DEPTH is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Active-low device select |
| oe_clr_n_i | input | 1 | Active-low output enable; low clears the position asynchronously |
| cfg_go_i | input | 1 | Configuration-in-progress enable, must be high to stream |
| busy_i | input | 1 | Target busy flag; stalls byte-wide transfers |
| byte_mode_i | input | 1 | 0 = bit-serial on pin 0, 1 = byte-wide on pins 7..0 |
| prog_i | input | 1 | Programming mode; forces the safe output state |
| data_o | output | 8 | Data pins |
| data_en_o | output | 8 | Per-pin drive enable (0 = high-impedance) |
| chain_en_n_o | output | 1 | Active-low enable for the next device in a chain |

## Verification
The critical overlap is a busy stall falling in the cycle that presents the final word. If the stall is ignored, the end flag is raised too early and the last byte is lost. The bench forces `busy_i` high the first time address DEPTH-1 is on the pins. It then checks that the same byte is still driven and `chain_en_n_o` is still 1 one edge later. Only after `busy_i` falls does it expect the pins to release and `chain_en_n_o` to drop. A second overlap is the asynchronous clear arriving while the end flag is set. For that case, `chain_en_n_o` must return to 1 before the next clock edge.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BIT_W  = $clog2(BYTE_W);

    typedef enum logic {
        XFER_SERIAL = 1'b0,
        XFER_BYTE   = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic       en;
        xfer_mode_e mode;
        logic       busy;
    } step_ctl_t;

    function automatic logic [BYTE_W-1:0] image_word(input int unsigned a);
        int unsigned v;
        v = (a * 29 + 71) % 256;
        return BYTE_W'(v);
    endfunction

endpackage

// File: rtl/cfgrom_store.sv
module cfgrom_store
    import cfgrom_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0]     addr_i,
    output logic [BYTE_W-1:0] word_o
);

    logic [BYTE_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign cells[i] = image_word(i);
    end

    assign word_o = cells[addr_i];

endmodule

// File: rtl/cfgrom_seq.sv
module cfgrom_seq
    import cfgrom_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             oe_clr_n_i,
    input  step_ctl_t        ctl_i,
    output logic [AW-1:0]    addr_o,
    output logic [BIT_W-1:0] bitp_o,
    output logic             done_o
);

    logic step;
    logic word_end;

    assign step     = ctl_i.en && !done_o &&
                      ((ctl_i.mode == XFER_SERIAL) || !ctl_i.busy);
    assign word_end = (ctl_i.mode == XFER_BYTE) ||
                      (bitp_o == BIT_W'(BYTE_W - 1));

    always_ff @(posedge clk_i or negedge oe_clr_n_i) begin
        if (!oe_clr_n_i) begin
            addr_o <= '0;
            bitp_o <= '0;
            done_o <= 1'b0;
        end else if (rst_i) begin
            addr_o <= '0;
            bitp_o <= '0;
            done_o <= 1'b0;
        end else if (step) begin
            if (ctl_i.mode == XFER_SERIAL) begin
                bitp_o <= word_end ? '0 : bitp_o + 1'b1;
            end
            if (word_end) begin
                if (addr_o == LAST) begin
                    done_o <= 1'b1;
                end else begin
                    addr_o <= addr_o + 1'b1;
                end
            end
        end
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (rst_i || !oe_clr_n_i)
        !ctl_i.en |=> ($stable(addr_o) && $stable(bitp_o))); // R7

    AST_BUSY_STALL: assert property (@(posedge clk_i) disable iff (rst_i || !oe_clr_n_i)
        (ctl_i.en && ctl_i.mode == XFER_BYTE && ctl_i.busy) |=> $stable(addr_o)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (rst_i || !oe_clr_n_i)
        done_o |=> done_o); // R8

    AST_SERIAL_INWORD: assert property (@(posedge clk_i) disable iff (rst_i || !oe_clr_n_i)
        (ctl_i.en && ctl_i.mode == XFER_SERIAL && !done_o && bitp_o != BIT_W'(BYTE_W - 1))
        |=> ($stable(addr_o) && bitp_o == BIT_W'($past(bitp_o) + 1'b1))); // R4

    AST_BYTE_ADVANCE: assert property (@(posedge clk_i) disable iff (rst_i || !oe_clr_n_i)
        (ctl_i.en && ctl_i.mode == XFER_BYTE && !ctl_i.busy && !done_o && addr_o != LAST)
        |=> (addr_o == AW'($past(addr_o) + 1'b1))); // R5

endmodule

// File: rtl/cfgrom_drive.sv
module cfgrom_drive
    import cfgrom_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  xfer_mode_e        mode_i,
    input  logic              prog_i,
    input  logic              done_i,
    input  logic [BYTE_W-1:0] word_i,
    input  logic [BIT_W-1:0]  bitp_i,
    output logic [BYTE_W-1:0] data_o,
    output logic [BYTE_W-1:0] data_en_o,
    output logic              chain_en_n_o
);

    logic present;
    logic cur_bit;

    assign present = en_i && !done_i;
    assign cur_bit = word_i[BIT_W'(BYTE_W - 1) - bitp_i];

    always_comb begin
        data_o    = '0;
        data_en_o = '0;
        if (present) begin
            if (mode_i == XFER_BYTE) begin
                data_o    = word_i;
                data_en_o = '1;
            end else begin
                data_o[0]    = cur_bit;
                data_en_o[0] = 1'b1;
            end
        end
    end

    assign chain_en_n_o = prog_i || !done_i;

    AST_PROG_SAFE: assert property (@(posedge clk_i) disable iff (rst_i)
        prog_i |-> (chain_en_n_o && data_en_o == '0)); // R9

    AST_RELEASED_AFTER_END: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_i && !prog_i) |-> (!chain_en_n_o && data_en_o == '0)); // R8

    AST_SERIAL_ONE_PIN: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == XFER_SERIAL) |-> (data_en_o[BYTE_W-1:1] == '0)); // R3

endmodule

// File: rtl/cfg_rom_stream.sv
module cfg_rom_stream
    import cfgrom_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        sel_n_i,
    input  logic        oe_clr_n_i,
    input  logic        cfg_go_i,
    input  logic        busy_i,
    input  logic        byte_mode_i,
    input  logic        prog_i,
    output logic [7:0]  data_o,
    output logic [7:0]  data_en_o,
    output logic        chain_en_n_o
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    step_ctl_t         ctl;
    logic [AW-1:0]     addr;
    logic [BIT_W-1:0]  bitp;
    logic              done;
    logic [BYTE_W-1:0] word;

    assign ctl.en   = !sel_n_i && oe_clr_n_i && cfg_go_i && !prog_i;
    assign ctl.mode = byte_mode_i ? XFER_BYTE : XFER_SERIAL;
    assign ctl.busy = busy_i;

    cfgrom_store #(.DEPTH(DEPTH)) u_store (
        .addr_i (addr),
        .word_o (word)
    );

    cfgrom_seq #(.DEPTH(DEPTH)) u_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .oe_clr_n_i (oe_clr_n_i),
        .ctl_i      (ctl),
        .addr_o     (addr),
        .bitp_o     (bitp),
        .done_o     (done)
    );

    cfgrom_drive u_drive (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .en_i         (ctl.en),
        .mode_i       (ctl.mode),
        .prog_i       (prog_i),
        .done_i       (done),
        .word_i       (word),
        .bitp_i       (bitp),
        .data_o       (data_o),
        .data_en_o    (data_en_o),
        .chain_en_n_o (chain_en_n_o)
    );

    AST_GATED_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_n_i || !cfg_go_i || !oe_clr_n_i) |-> (data_en_o == 8'h00 && data_o == 8'h00)); // R2

endmodule

// File: tb/cfg_rom_stream_tb.sv
module cfg_rom_stream_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       sel_n_i = 1'b1;
    logic       oe_clr_n_i = 1'b1;
    logic       cfg_go_i = 1'b0;
    logic       busy_i = 1'b0;
    logic       byte_mode_i = 1'b0;
    logic       prog_i = 1'b0;
    logic [7:0] data_o;
    logic [7:0] data_en_o;
    logic       chain_en_n_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    cfg_rom_stream #(.DEPTH(DEPTH)) dut_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .sel_n_i      (sel_n_i),
        .oe_clr_n_i   (oe_clr_n_i),
        .cfg_go_i     (cfg_go_i),
        .busy_i       (busy_i),
        .byte_mode_i  (byte_mode_i),
        .prog_i       (prog_i),
        .data_o       (data_o),
        .data_en_o    (data_en_o),
        .chain_en_n_o (chain_en_n_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    function automatic logic [7:0] ref_word(input int a);
        return 8'((a * 29 + 71) % 256);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Gating interlude in the middle of a serial word: position must hold.
    task automatic hold_probe();
        sel_n_i = 1'b1;
        #1 check("R7 sel off released", {24'd0, data_en_o}, 32'h00);
        @(negedge clk_i);
        #1 check("R2 sel off data zero", {24'd0, data_o}, 32'h00);
        sel_n_i = 1'b0; cfg_go_i = 1'b0;
        #1 check("R7 cfg_go low released", {24'd0, data_en_o}, 32'h00);
        @(negedge clk_i);
        cfg_go_i = 1'b1; prog_i = 1'b1;
        #1 check("R9 prog chain high", {31'd0, chain_en_n_o}, 32'h1);
        check("R9 prog released", {24'd0, data_en_o}, 32'h00);
        @(negedge clk_i);
        prog_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int a;
        bit stalled_last;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_i = 1'b0;
        #1 check("R1 reset chain high", {31'd0, chain_en_n_o}, 32'h1);
        check("R2 reset deselected released", {24'd0, data_en_o}, 32'h00);

        // Serial sweep over the whole store (R3, R4, R10)
        sel_n_i = 1'b0; cfg_go_i = 1'b1; byte_mode_i = 1'b0;
        for (int w = 0; w < DEPTH; w++) begin
            for (int b = 0; b < 8; b++) begin
                if (w == 2 && b == 3) hold_probe();
                #1;
                check($sformatf("R3 R10 serial w%0d b%0d", w, b), {31'd0, data_o[0]}, {31'd0, ref_word(w)[7-b]});
                check("R3 serial pin enable", {24'd0, data_en_o}, 32'h01);
                check("R4 chain high mid stream", {31'd0, chain_en_n_o}, 32'h1);
                @(negedge clk_i);
            end
        end
        #1 check("R8 serial end chain low", {31'd0, chain_en_n_o}, 32'h0);
        check("R8 serial end released", {24'd0, data_en_o}, 32'h00);
        @(negedge clk_i);
        #1 check("R8 end persists", {24'd0, data_en_o}, 32'h00);
        prog_i = 1'b1;
        #1 check("R9 prog after end chain high", {31'd0, chain_en_n_o}, 32'h1);
        prog_i = 1'b0;

        // Asynchronous clear while ended (R1)
        oe_clr_n_i = 1'b0;
        #1 check("R1 async clear chain high", {31'd0, chain_en_n_o}, 32'h1);
        check("R2 oe low released", {24'd0, data_en_o}, 32'h00);
        @(negedge clk_i);
        oe_clr_n_i = 1'b1; byte_mode_i = 1'b1;

        // Byte-wide sweep with busy pattern (R5, R6, R10)
        a = 0;
        stalled_last = 0;
        for (int cyc = 0; cyc < 200 && a < DEPTH; cyc++) begin
            busy_i = (cyc % 3 == 2) || (a == DEPTH - 1 && !stalled_last);
            if (a == DEPTH - 1 && busy_i) stalled_last = 1;
            #1;
            check($sformatf("R5 R10 byte a%0d", a), {24'd0, data_o}, {24'd0, ref_word(a)});
            check("R5 byte enable", {24'd0, data_en_o}, 32'hFF);
            check("R6 R8 chain high before end", {31'd0, chain_en_n_o}, 32'h1);
            if (!busy_i) a++;
            @(negedge clk_i);
        end
        busy_i = 1'b0;
        #1 check("R8 byte end chain low", {31'd0, chain_en_n_o}, 32'h0);
        check("R8 byte end released", {24'd0, data_en_o}, 32'h00);

        // Synchronous reset (R1)
        rst_i = 1'b1; byte_mode_i = 1'b0;
        @(negedge clk_i);
        rst_i = 1'b0;
        #1 check("R1 sync reset chain high", {31'd0, chain_en_n_o}, 32'h1);
        check("R1 sync reset first bit", {31'd0, data_o[0]}, {31'd0, ref_word(0)[7]});

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule